// File: doc/BRIEF.md
# Leader-Follower Redundant Execution Checker

This block pairs two cores that run the same program without lockstep: a leading core and a trailing core that runs a fixed number of instructions behind it. Every memory access and branch the leader makes becomes an entry in an in-order queue. An entry holds a kind tag, an address and a data word. The queue hands each entry to the trailer in program order. The trailer takes its load values from the forwarded data word and never reads memory itself.

When the trailer retires the same operation, the block compares what the trailer computed with the head entry. A store goes out on the memory write port only once the trailer has produced the same address and the same data. Any disagreement raises a sticky error, discards the disagreeing store and empties the queue. Recovery is left to the system around the block.

The queue depth is the lag plus a slack margin. The leader is stalled whenever the queue is full.

Top module: `lf_redund_chk`

## Requirements
- R1: After reset, `lead_ready` is 1, and `fwd_valid`, `mem_wr_valid` and `mismatch_err` are 0.
- R2: While no error is present, `fwd_valid` is 1 exactly when the queue holds entries. `fwd_kind`, `fwd_addr` and `fwd_data` show the oldest entry, and entries appear in the order the leader pushed them.
- R3: The queue holds LAG+SLACK entries (8 by default). `lead_ready` is 0 when the queue is full or an error is present, and a push offered while `lead_ready` is 0 is not stored.
- R4: Kind codes are 1 for a load, 2 for a branch and 3 for a store. A load matches when the kinds and the addresses are equal; the trailer's data word is ignored.
- R5: A branch matches when the kinds are equal, the addresses (targets) are equal and data bit 0 (taken) is equal. Data bits 31:1 are ignored.
- R6: A store matches only when both address and data are equal. On a match, `mem_wr_valid` is 1 in the next cycle with that address and data.
- R7: A pending memory write keeps its address and data until `mem_wr_ready`. `trl_ready` is 1 only when an entry is forwarded and the write slot is free or draining in that cycle, so at most one write is issued per cycle.
- R8: A retire whose kind differs from the head entry's kind is a mismatch. Any entry of kind 0 is also a mismatch.
- R9: A mismatch sets `mismatch_err` in the next cycle and empties the queue, including any push accepted in that cycle. A mismatching store is never written. While the error is set, `lead_ready`, `trl_ready` and `fwd_valid` are 0.
- R10: `mismatch_err` stays set until a cycle with `err_clear` high, and is 0 from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lead_valid | input | 1 | Leader offers an entry |
| lead_kind | input | 2 | Entry kind (1 load, 2 branch, 3 store) |
| lead_addr | input | 32 | Leader address or branch target |
| lead_data | input | 32 | Load value, taken bit or store data |
| lead_ready | output | 1 | Queue accepts the entry |
| fwd_valid | output | 1 | Oldest entry available to trailer |
| fwd_kind | output | 2 | Oldest entry kind |
| fwd_addr | output | 32 | Oldest entry address |
| fwd_data | output | 32 | Oldest entry data (load value for the trailer) |
| trl_valid | input | 1 | Trailer retires an operation |
| trl_kind | input | 2 | Trailer operation kind |
| trl_addr | input | 32 | Trailer computed address |
| trl_data | input | 32 | Trailer taken bit or store data |
| trl_ready | output | 1 | Retire is accepted and compared |
| mem_wr_valid | output | 1 | Verified store pending |
| mem_wr_addr | output | 32 | Store address |
| mem_wr_data | output | 32 | Store data |
| mem_wr_ready | input | 1 | Memory accepts the store |
| mismatch_err | output | 1 | Sticky comparison error |
| err_clear | input | 1 | Synchronous error clear |

## Verification
Two overlaps are provoked on purpose. The first is a leader push, a trailer retire and a memory-write drain all in the same cycle. Random valid and ready patterns create it, and a bench queue model predicts the occupancy, the head entry and the write slot. The second is a leader push landing in the same cycle as a mismatching retire. A directed case does this and then expects an empty queue, no write and a set error one cycle later. A full queue with a simultaneous retire, and a store retire blocked while the write slot waits under backpressure, are also checked against the model.

// File: rtl/lfchk_pkg.sv
package lfchk_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    K_NONE   = 2'd0,
    K_LOAD   = 2'd1,
    K_BRANCH = 2'd2,
    K_STORE  = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] data;
  } entry_t;

  // Per-kind comparison of a leader entry against a trailer retire.
  function automatic logic entry_match(entry_t lead, entry_t trail);
    logic r;
    r = 1'b0;
    if (lead.kind == trail.kind) begin
      case (lead.kind)
        K_LOAD:   r = (lead.addr == trail.addr);
        K_BRANCH: r = (lead.addr == trail.addr) && (lead.data[0] == trail.data[0]);
        K_STORE:  r = (lead.addr == trail.addr) && (lead.data == trail.data);
        default:  r = 1'b0;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/lfchk_fifo.sv
module lfchk_fifo
  import lfchk_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   flush,
  input  logic   push,
  input  entry_t din,
  input  logic   pop,
  output entry_t dout,
  output logic   empty,
  output logic   full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  entry_t         store_q [DEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]  count;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign dout  = store_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) store_q[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/lfchk_cmp.sv
module lfchk_cmp
  import lfchk_pkg::*;
(
  input  entry_t lead,
  input  entry_t trail,
  output logic   same
);
  assign same = entry_match(lead, trail);
endmodule

// File: rtl/lfchk_wslot.sv
module lfchk_wslot
  import lfchk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] in_addr,
  input  logic [WORD_W-1:0] in_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_addr,
  output logic [WORD_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_addr  <= in_addr;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lf_redund_chk.sv
module lf_redund_chk
  import lfchk_pkg::*;
#(
  parameter int LAG   = 6,
  parameter int SLACK = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lead_valid,
  input  logic [1:0]  lead_kind,
  input  logic [31:0] lead_addr,
  input  logic [31:0] lead_data,
  output logic        lead_ready,
  output logic        fwd_valid,
  output logic [1:0]  fwd_kind,
  output logic [31:0] fwd_addr,
  output logic [31:0] fwd_data,
  input  logic        trl_valid,
  input  logic [1:0]  trl_kind,
  input  logic [31:0] trl_addr,
  input  logic [31:0] trl_data,
  output logic        trl_ready,
  output logic        mem_wr_valid,
  output logic [31:0] mem_wr_addr,
  output logic [31:0] mem_wr_data,
  input  logic        mem_wr_ready,
  output logic        mismatch_err,
  input  logic        err_clear
);
  localparam int QDEPTH = LAG + SLACK;

  entry_t lead_e, trail_e, head_e;
  logic   q_empty, q_full;
  logic   q_push, q_pop, flush;
  logic   cmp_ok, cmp_bad, store_rel, slot_free;
  logic   err_q;

  assign lead_e  = '{kind: kind_e'(lead_kind), addr: lead_addr, data: lead_data};
  assign trail_e = '{kind: kind_e'(trl_kind),  addr: trl_addr,  data: trl_data};

  assign lead_ready = !q_full && !err_q;
  assign q_push     = lead_valid && lead_ready;
  assign fwd_valid  = !q_empty && !err_q;
  assign slot_free  = !mem_wr_valid || mem_wr_ready;
  assign trl_ready  = fwd_valid && slot_free;
  assign q_pop      = trl_valid && trl_ready;
  assign cmp_bad    = q_pop && !cmp_ok;
  assign store_rel  = q_pop && cmp_ok && (head_e.kind == K_STORE);
  assign flush      = cmp_bad;

  assign fwd_kind = head_e.kind;
  assign fwd_addr = head_e.addr;
  assign fwd_data = head_e.data;
  assign mismatch_err = err_q;

  lfchk_fifo #(.DEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(q_push), .din(lead_e),
    .pop(q_pop), .dout(head_e),
    .empty(q_empty), .full(q_full)
  );

  lfchk_cmp u_cmp (.lead(head_e), .trail(trail_e), .same(cmp_ok));

  lfchk_wslot u_wslot (
    .clk(clk), .rst_n(rst_n), .load(store_rel),
    .in_addr(trl_addr), .in_data(trl_data),
    .out_ready(mem_wr_ready), .out_valid(mem_wr_valid),
    .out_addr(mem_wr_addr), .out_data(mem_wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         err_q <= 1'b0;
    else if (cmp_bad)   err_q <= 1'b1;
    else if (err_clear) err_q <= 1'b0;
  end
endmodule

// File: rtl/lfchk_sva.sv
module lfchk_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        lead_ready,
  input logic        fwd_valid,
  input logic        trl_valid,
  input logic        trl_ready,
  input logic [31:0] trl_addr,
  input logic [31:0] trl_data,
  input logic        mem_wr_valid,
  input logic        mem_wr_ready,
  input logic [31:0] mem_wr_addr,
  input logic [31:0] mem_wr_data,
  input logic        mismatch_err,
  input logic        err_clear,
  input logic        cmp_bad,
  input logic        store_rel,
  input logic        q_full
);
  // R3
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_full && !(trl_valid && trl_ready) |=> !lead_ready);

  // R6
  store_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_rel |=> mem_wr_valid && mem_wr_addr == $past(trl_addr)
                  && mem_wr_data == $past(trl_data));

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr)
                                      && $stable(mem_wr_data));

  // R9
  err_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_bad |=> mismatch_err && !fwd_valid);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_err && !err_clear |=> mismatch_err);

  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_err && err_clear |=> !mismatch_err);
endmodule

bind lf_redund_chk lfchk_sva u_sva (
  .clk(clk), .rst_n(rst_n), .lead_ready(lead_ready), .fwd_valid(fwd_valid),
  .trl_valid(trl_valid), .trl_ready(trl_ready), .trl_addr(trl_addr),
  .trl_data(trl_data), .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
  .mismatch_err(mismatch_err), .err_clear(err_clear), .cmp_bad(cmp_bad),
  .store_rel(store_rel), .q_full(q_full)
);

// File: tb/lf_redund_chk_tb.sv
module lf_redund_chk_tb;
  localparam int QD = 8;

  typedef struct {
    logic [1:0]  k;
    logic [31:0] a;
    logic [31:0] d;
  } ent_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lead_valid = 0, trl_valid = 0, mem_wr_ready = 0, err_clear = 0;
  logic [1:0]  lead_kind = 0, trl_kind = 0;
  logic [31:0] lead_addr = 0, lead_data = 0, trl_addr = 0, trl_data = 0;
  logic lead_ready, fwd_valid, trl_ready, mem_wr_valid, mismatch_err;
  logic [1:0]  fwd_kind;
  logic [31:0] fwd_addr, fwd_data, mem_wr_addr, mem_wr_data;

  always #5 clk = ~clk;

  lf_redund_chk u_dut (.*);

  int total = 0, bad = 0;
  bit done = 0;
  ent_t bq[$];
  bit eerr = 0, ewv = 0, last_push = 0, last_pop = 0;
  logic [31:0] ewa = 0, ewd = 0;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Match rule restated with per-kind data masks.
  function automatic bit bmatch(ent_t h, ent_t t);
    logic [31:0] m;
    m = (h.k == 2'd3) ? 32'hFFFF_FFFF : (h.k == 2'd2) ? 32'h1 : 32'h0;
    return (h.k == t.k) && (h.k != 2'd0) && (h.a == t.a) && (((h.d ^ t.d) & m) == 0);
  endfunction

  function automatic ent_t prog(int i);
    ent_t e;
    e.k = 2'(1 + ((i ^ (i >> 2)) % 3));
    e.a = 32'h1000 + 32'(i) * 4;
    e.d = 32'(i) * 32'h9E37 ^ 32'h55;
    return e;
  endfunction

  // Trailer view: load data free, branch upper bits disturbed.
  function automatic ent_t tview(ent_t e);
    ent_t t = e;
    if (e.k == 2'd1) t.d = $urandom;
    if (e.k == 2'd2) t.d = e.d ^ 32'hFFFF_FFFE;
    return t;
  endfunction

  task automatic step(bit lv, ent_t le, bit tv, ent_t te, bit mr, bit clr);
    bit exp_lr, exp_fv, exp_tr, pf, pp, mf, badc;
    ent_t h;
    @(negedge clk);
    lead_valid = lv; lead_kind = le.k; lead_addr = le.a; lead_data = le.d;
    trl_valid = tv; trl_kind = te.k; trl_addr = te.a; trl_data = te.d;
    mem_wr_ready = mr; err_clear = clr;
    #1;
    exp_lr = !eerr && bq.size() < QD;
    chk("R3 lead_ready", 64'(lead_ready), 64'(exp_lr));
    exp_fv = !eerr && bq.size() > 0;
    chk("R2 fwd_valid", 64'(fwd_valid), 64'(exp_fv));
    if (exp_fv) begin
      chk("R2 fwd_kind", 64'(fwd_kind), 64'(bq[0].k));
      chk("R2 fwd_addr", 64'(fwd_addr), 64'(bq[0].a));
      chk("R2 fwd_data", 64'(fwd_data), 64'(bq[0].d));
    end
    exp_tr = exp_fv && (!ewv || mr);
    chk("R7 trl_ready", 64'(trl_ready), 64'(exp_tr));
    chk("R6 mem_wr_valid", 64'(mem_wr_valid), 64'(ewv));
    if (ewv) begin
      chk("R6 mem_wr_addr", 64'(mem_wr_addr), 64'(ewa));
      chk("R6 mem_wr_data", 64'(mem_wr_data), 64'(ewd));
    end
    chk("R9 mismatch_err", 64'(mismatch_err), 64'(eerr));
    pf = lv && exp_lr; pp = tv && exp_tr; mf = ewv && mr; badc = 0;
    @(posedge clk);
    if (mf) ewv = 0;
    if (pp) begin
      h = bq.pop_front();
      if (bmatch(h, te)) begin
        if (h.k == 2'd3) begin ewv = 1; ewa = te.a; ewd = te.d; end
      end else badc = 1;
    end
    if (pf) bq.push_back(le);
    if (badc) begin eerr = 1; bq.delete(); end
    else if (clr) eerr = 0;
    last_push = pf; last_pop = pp;
  endtask

  task automatic probe();
    @(negedge clk);
    lead_valid = 0; trl_valid = 0; mem_wr_ready = 0; err_clear = 0;
    #1;
  endtask

  task automatic idle(bit mr, bit clr);
    ent_t z = '{2'd0, 32'd0, 32'd0};
    step(0, z, 0, z, mr, clr);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung got=timeout exp=finish");
    finish_run();
  end

  initial begin
    ent_t z, e, s1, s2, t;
    int li, ti;
    z = '{2'd0, 32'd0, 32'd0};
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk("R1 lead_ready", 64'(lead_ready), 64'd1);
    chk("R1 fwd_valid", 64'(fwd_valid), 64'd0);
    chk("R1 mem_wr_valid", 64'(mem_wr_valid), 64'd0);
    chk("R1 mismatch_err", 64'(mismatch_err), 64'd0);

    // R3: fill to capacity, ninth push refused, order kept on drain
    for (int i = 0; i < QD + 1; i++) step(1, prog(i), 0, z, 0, 0);
    chk("R3 push refused when full", 64'(last_push), 64'd0);
    for (int i = 0; i < QD; i++) step(0, z, 1, tview(prog(i)), 1, 0);
    idle(1, 0);
    probe();
    chk("R4 load data ignored, no error", 64'(mismatch_err), 64'd0);

    // R6: matched store issued next cycle
    e = '{2'd3, 32'hA000, 32'hDEAD_BEEF};
    step(1, e, 0, z, 0, 0);
    step(0, z, 1, e, 0, 0);
    probe();
    chk("R6 store issued", 64'(mem_wr_valid), 64'd1);
    chk("R6 store addr", 64'(mem_wr_addr), 64'hA000);
    idle(1, 0);

    // R7: second store blocked while slot waits
    s1 = '{2'd3, 32'hB000, 32'h1111}; s2 = '{2'd3, 32'hB004, 32'h2222};
    step(1, s1, 0, z, 0, 0);
    step(1, s2, 0, z, 0, 0);
    step(0, z, 1, s1, 0, 0);
    step(0, z, 1, s2, 0, 0);
    chk("R7 retire blocked by full slot", 64'(last_pop), 64'd0);
    step(0, z, 1, s2, 0, 0);
    step(0, z, 1, s2, 1, 0);
    chk("R7 retire with draining slot", 64'(last_pop), 64'd1);
    probe();
    chk("R7 second store data", 64'(mem_wr_data), 64'h2222);
    idle(1, 0);

    // R5: taken bit differs
    e = '{2'd2, 32'hC000, 32'h1};
    step(1, e, 0, z, 0, 0);
    t = e; t.d = 32'h0;
    step(0, z, 1, t, 0, 0);
    probe();
    chk("R5 taken bit mismatch", 64'(mismatch_err), 64'd1);
    repeat (3) idle(0, 0);
    probe();
    chk("R10 error held", 64'(mismatch_err), 64'd1);
    idle(0, 1);
    probe();
    chk("R10 error cleared", 64'(mismatch_err), 64'd0);

    // R8: kind mismatch with a push in the same cycle
    e = '{2'd1, 32'hD000, 32'h5};
    step(1, e, 0, z, 0, 0);
    step(1, prog(3), 0, z, 0, 0);
    t = e; t.k = 2'd3;
    step(1, prog(4), 1, t, 0, 0);
    probe();
    chk("R8 kind mismatch error", 64'(mismatch_err), 64'd1);
    chk("R9 queue flushed", 64'(fwd_valid), 64'd0);
    step(1, prog(5), 0, z, 0, 0);
    chk("R9 push refused in error", 64'(last_push), 64'd0);
    idle(0, 1);

    // R9: store data mismatch never written
    e = '{2'd3, 32'hE000, 32'h7777};
    step(1, e, 0, z, 0, 0);
    step(1, prog(6), 0, z, 0, 0);
    t = e; t.d = 32'h7776;
    step(0, z, 1, t, 1, 0);
    probe();
    chk("R9 bad store dropped", 64'(mem_wr_valid), 64'd0);
    chk("R9 queue emptied", 64'(fwd_valid), 64'd0);
    idle(0, 1);

    // Random phase: concurrent push, retire and drain
    li = 0; ti = 0;
    for (int c = 0; c < 3000; c++) begin
      bit lv, tv, mr;
      lv = ($urandom % 10) < 6;
      tv = ($urandom % 10) < 6;
      mr = ($urandom % 10) < 7;
      step(lv, prog(100 + li), tv, tview(prog(100 + ti)), mr, 0);
      if (last_push) li++;
      if (last_pop) ti++;
    end
    repeat (QD + 4) step(0, z, 1, tview(prog(100 + ti)), 1, 0);
    finish_run();
  end
endmodule